// File: doc/BRIEF.md
# Successive-Approximation ADC Conversion Sequencer

This block is the digital timing controller of a 10-bit successive-approximation converter. A programmable divider turns the system clock into an ADC clock, delivered as a one-cycle `rise` enable with a matching mid-period `fall` phase. A sequencer turns a software start request into a timed conversion. It pulses a channel/reference update strobe on the start edge, fires a sample-and-hold strobe on a falling phase, and samples a comparator decision bit once per ADC clock, most significant bit first. At the end it latches the 10-bit result and raises a sticky completion flag.

The first conversion after the enable input is raised is an extended one: it is longer and it samples later, so the analog front end can settle. In differential mode a conversion may begin only on alternate ADC clock edges. Single-conversion mode drops the start bit when the result lands. Free-running mode keeps the start bit set and begins the next conversion on the completion edge.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The ADC clock rate is selected by `div_sel_i`: codes 0..7 divide by 2, 2, 4, 8, 16, 32, 64 and 128. While `enable_i` is low the divider is held cleared. If `enable_i` is first sampled high at the clock edge that closes observation cycle e, the ADC clock rises at observation cycles e + j*div - 1 for j = 1, 2, ...
- R2: Writing the start bit (`start_wr_i` high while `enable_i` is high) makes `start_o` read 1. The conversion begins on the first ADC clock rise after that. `mux_upd_o` pulses for one system cycle on that start edge. A start write while `enable_i` is low is ignored.
- R3: With `diff_i` high, a conversion that begins from idle may start only on odd-numbered ADC clock rises (j odd in R1), counted from enable.
- R4: The first conversion after enable lasts 25 ADC clock periods. `done_o` rises one system cycle after the rise that lies 25 periods after the start edge.
- R5: Every later conversion lasts 13 ADC clock periods, with the same completion timing.
- R6: `sample_o` pulses at 1.5 ADC periods after the start edge in a normal conversion and 13.5 periods in an extended one, i.e. div/2 system cycles after a rise.
- R7: For a conversion of length L, the comparator bit seen at rise number c (the start edge being c = 0) goes to result bit 9-(c-L+10) for c = L-10 .. L-1. `result_o` and `done_o` update on the completion edge.
- R8: `done_o` stays high until `done_clr_i` is pulsed. A clear takes effect one cycle later.
- R9: In single-conversion mode (`free_run_i` low), `start_o` drops on the same edge that sets `done_o`.
- R10: In free-running mode the next conversion starts on the completion rise itself, normal length, and `start_o` stays 1.
- R11: Lowering `enable_i` aborts a conversion in progress and clears `start_o` without setting `done_o`. The next conversion after re-enabling is extended again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Converter enable; low holds the divider and sequencer idle |
| start_wr_i | input | 1 | One-cycle write of 1 to the start bit |
| free_run_i | input | 1 | 1 = free-running, 0 = single conversion |
| diff_i | input | 1 | 1 = differential channel selected (alternate-edge start) |
| div_sel_i | input | 3 | ADC clock divider code |
| cmp_i | input | 1 | Comparator decision for the current bit step |
| done_clr_i | input | 1 | Write-1 clear of the completion flag |
| mux_upd_o | output | 1 | Channel/reference update strobe on the start edge |
| sample_o | output | 1 | Sample-and-hold strobe |
| result_o | output | 10 | Latched conversion result |
| done_o | output | 1 | Sticky completion flag |
| start_o | output | 1 | Start bit readback |

## Verification
The comparator input is driven by a pseudo-random function of the cycle count. A result therefore matches only if every bit decision falls on the exact ADC rise it belongs to and lands in the correct position, which also exposes an off-by-one bit window or a reversed bit order. Each of the eight divider codes runs one extended and one normal conversion, with start writes placed at different phases of the ADC clock, so the start-edge, strobe and completion times separate the two lengths and the per-code divide ratios. Differential and single-ended starts are issued at the same even-numbered phase: one must wait a full extra ADC period and the other must not. A free-running pair, an ignored start write while disabled and an aborted conversion cover the start-bit and re-arm rules.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_CONV = 1'b1
   } seq_state_e;

   // divide ratio minus one for a divider code; code 0 aliases code 1
   function automatic int unsigned div_term(input int unsigned code);
      int unsigned c;
      c = (code == 0) ? 1 : code;
      return (1 << c) - 1;
   endfunction

   // system cycles from a rise to the falling phase, minus one
   function automatic int unsigned div_half(input int unsigned code);
      int unsigned c;
      c = (code == 0) ? 1 : code;
      return (1 << (c - 1)) - 1;
   endfunction
endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
   parameter int PSEL_W = 3,
   parameter int CNT_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic [PSEL_W-1:0] sel_i,
   output logic              rise_o,
   output logic              fall_o,
   output logic              par_ok_o
);
   import adc_seq_pkg::*;

   localparam int NCODES = 1 << PSEL_W;

   generate
      if (CNT_W < NCODES - 1) begin : g_bad_width
         $error("adc_prescaler: CNT_W too narrow for the largest divide ratio");
      end
   endgenerate

   logic [CNT_W-1:0] term_lut [NCODES];
   logic [CNT_W-1:0] half_lut [NCODES];

   generate
      for (genvar c = 0; c < NCODES; c++) begin : g_lut
         assign term_lut[c] = CNT_W'(div_term(c));
         assign half_lut[c] = CNT_W'(div_half(c));
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             odd_q;
   logic [CNT_W-1:0] term;
   logic [CNT_W-1:0] half;

   assign term     = term_lut[sel_i];
   assign half     = half_lut[sel_i];
   assign rise_o   = en_i && (cnt_q == term);
   assign fall_o   = en_i && (cnt_q == half);
   assign par_ok_o = !odd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         odd_q <= 1'b0;
      end else if (!en_i) begin
         cnt_q <= '0;
         odd_q <= 1'b0;
      end else if (rise_o) begin
         cnt_q <= '0;
         odd_q <= !odd_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R1: divide ratio is at least two, so rises never come back to back
   a_r1_rise_spaced: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
   // R1: nothing rises in the cycle after the divider was held
   a_r1_held_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !rise_o);
   // R6: the falling phase sits strictly between rises
   a_r6_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_o && fall_o));
endmodule

// File: rtl/adc_sar_result.sv
module adc_sar_result #(
   parameter int RES_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             shift_i,
   input  logic             bit_i,
   input  logic             latch_i,
   output logic [RES_W-1:0] result_o
);
   generate
      if (RES_W < 2) begin : g_bad_res
         $error("adc_sar_result: RES_W must be at least 2");
      end
   endgenerate

   logic [RES_W-1:0] sr_q;
   logic [RES_W-1:0] res_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '0;
      end else if (clr_i) begin
         sr_q <= '0;
      end else if (shift_i) begin
         sr_q <= {sr_q[RES_W-2:0], bit_i};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q <= '0;
      end else if (latch_i) begin
         res_q <= sr_q;
      end
   end

   assign result_o = res_q;

   // R7: the result register only moves on a completion edge
   a_r7_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_i |=> $stable(res_q));
endmodule

// File: rtl/adc_sequencer.sv
module adc_sequencer #(
   parameter int RES_W    = 10,
   parameter int NORM_LEN = 13,
   parameter int EXT_LEN  = 25,
   parameter int NORM_SH  = 1,
   parameter int EXT_SH   = 13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic start_wr_i,
   input  logic free_run_i,
   input  logic diff_i,
   input  logic done_clr_i,
   input  logic rise_i,
   input  logic fall_i,
   input  logic par_ok_i,
   output logic mux_upd_o,
   output logic sample_o,
   output logic shift_o,
   output logic latch_o,
   output logic clr_sr_o,
   output logic done_o,
   output logic start_o
);
   import adc_seq_pkg::*;

   localparam int CYC_W = $clog2(EXT_LEN + 1);
   localparam logic [CYC_W-1:0] NORM_C   = CYC_W'(NORM_LEN);
   localparam logic [CYC_W-1:0] EXT_C    = CYC_W'(EXT_LEN);
   localparam logic [CYC_W-1:0] NORM_SHC = CYC_W'(NORM_SH + 1);
   localparam logic [CYC_W-1:0] EXT_SHC  = CYC_W'(EXT_SH + 1);
   localparam logic [CYC_W-1:0] RES_C    = CYC_W'(RES_W);

   generate
      if (NORM_LEN - RES_W < NORM_SH + 2) begin : g_bad_norm
         $error("adc_sequencer: normal bit window overlaps the sample point");
      end
      if (EXT_LEN - RES_W < EXT_SH + 2) begin : g_bad_ext
         $error("adc_sequencer: extended bit window overlaps the sample point");
      end
      if (EXT_LEN < NORM_LEN) begin : g_bad_len
         $error("adc_sequencer: extended conversion shorter than normal");
      end
   endgenerate

   seq_state_e       st_q;
   logic [CYC_W-1:0] cyc_q;
   logic             ext_q;
   logic             ext_pend_q;
   logic             sbit_q;
   logic             done_q;

   logic [CYC_W-1:0] cur_len;
   logic [CYC_W-1:0] cur_sh;
   logic [CYC_W-1:0] win_lo;
   logic             done_now;
   logic             idle_go;
   logic             fr_go;
   logic             cnv_start;

   assign cur_len   = ext_q ? EXT_C : NORM_C;
   assign cur_sh    = ext_q ? EXT_SHC : NORM_SHC;
   assign win_lo    = cur_len - RES_C;
   assign done_now  = en_i && (st_q == SEQ_CONV) && rise_i && (cyc_q == cur_len);
   assign idle_go   = (st_q == SEQ_IDLE) && (!diff_i || par_ok_i);
   assign fr_go     = done_now && free_run_i;
   assign cnv_start = en_i && rise_i && sbit_q && (idle_go || fr_go);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= SEQ_IDLE;
         cyc_q      <= '0;
         ext_q      <= 1'b0;
         ext_pend_q <= 1'b1;
      end else if (!en_i) begin
         st_q       <= SEQ_IDLE;
         cyc_q      <= '0;
         ext_pend_q <= 1'b1;
      end else if (cnv_start) begin
         st_q       <= SEQ_CONV;
         cyc_q      <= CYC_W'(1);
         ext_q      <= ext_pend_q;
         ext_pend_q <= 1'b0;
      end else if (done_now) begin
         st_q  <= SEQ_IDLE;
         cyc_q <= '0;
      end else if ((st_q == SEQ_CONV) && rise_i) begin
         cyc_q <= cyc_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sbit_q <= 1'b0;
      end else if (!en_i) begin
         sbit_q <= 1'b0;
      end else if (start_wr_i) begin
         sbit_q <= 1'b1;
      end else if (done_now && !free_run_i) begin
         sbit_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
      end else if (done_now) begin
         done_q <= 1'b1;
      end else if (done_clr_i) begin
         done_q <= 1'b0;
      end
   end

   assign mux_upd_o = cnv_start;
   assign clr_sr_o  = cnv_start;
   assign latch_o   = done_now;
   assign sample_o  = en_i && (st_q == SEQ_CONV) && fall_i && (cyc_q == cur_sh);
   assign shift_o   = en_i && (st_q == SEQ_CONV) && rise_i &&
                      (cyc_q >= win_lo) && (cyc_q < cur_len);
   assign done_o    = done_q;
   assign start_o   = sbit_q;

   // R2: a conversion only begins on an ADC clock rise
   a_r2_start_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      mux_upd_o |-> rise_i);
   // R6: the sample strobe is never on a rising phase
   a_r6_sample_mid: assert property (@(posedge clk) disable iff (!rst_n)
      sample_o |-> !rise_i);
   // R7: completion raises the flag on the next cycle
   a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      latch_o |=> done_o);
   // R9: single mode drops the start bit with the completion edge
   a_r9_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_o && !free_run_i && !start_wr_i) |=> !start_o);
   // R10: free running restarts on the completion rise and keeps the start bit
   a_r10_fr_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_o && free_run_i) |-> (mux_upd_o && start_o));
   // R11: no completion while disabled
   a_r11_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |-> !latch_o);
   // R8: the flag only falls through a clear write
   a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !done_clr_i) |=> done_o);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
   parameter int PSEL_W   = 3,
   parameter int RES_W    = 10,
   parameter int NORM_LEN = 13,
   parameter int EXT_LEN  = 25,
   parameter int NORM_SH  = 1,
   parameter int EXT_SH   = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable_i,
   input  logic              start_wr_i,
   input  logic              free_run_i,
   input  logic              diff_i,
   input  logic [PSEL_W-1:0] div_sel_i,
   input  logic              cmp_i,
   input  logic              done_clr_i,
   output logic              mux_upd_o,
   output logic              sample_o,
   output logic [RES_W-1:0]  result_o,
   output logic              done_o,
   output logic              start_o
);
   localparam int CNT_W = (1 << PSEL_W) - 1;

   logic rise;
   logic fall;
   logic par_ok;
   logic shift;
   logic latch;
   logic clr_sr;

   adc_prescaler #(
      .PSEL_W (PSEL_W),
      .CNT_W  (CNT_W)
   ) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (enable_i),
      .sel_i    (div_sel_i),
      .rise_o   (rise),
      .fall_o   (fall),
      .par_ok_o (par_ok)
   );

   adc_sequencer #(
      .RES_W    (RES_W),
      .NORM_LEN (NORM_LEN),
      .EXT_LEN  (EXT_LEN),
      .NORM_SH  (NORM_SH),
      .EXT_SH   (EXT_SH)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (enable_i),
      .start_wr_i (start_wr_i),
      .free_run_i (free_run_i),
      .diff_i     (diff_i),
      .done_clr_i (done_clr_i),
      .rise_i     (rise),
      .fall_i     (fall),
      .par_ok_i   (par_ok),
      .mux_upd_o  (mux_upd_o),
      .sample_o   (sample_o),
      .shift_o    (shift),
      .latch_o    (latch),
      .clr_sr_o   (clr_sr),
      .done_o     (done_o),
      .start_o    (start_o)
   );

   adc_sar_result #(
      .RES_W (RES_W)
   ) u_res (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (clr_sr),
      .shift_i  (shift),
      .bit_i    (cmp_i),
      .latch_i  (latch),
      .result_o (result_o)
   );
endmodule

// File: tb/tb_adc_seq_ctrl.sv
`timescale 1ns/1ps
module tb_adc_seq_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable_i = 1'b0;
   logic       start_wr_i = 1'b0;
   logic       free_run_i = 1'b0;
   logic       diff_i = 1'b0;
   logic [2:0] div_sel_i = 3'd0;
   logic       cmp_i = 1'b0;
   logic       done_clr_i = 1'b0;
   logic       mux_upd_o;
   logic       sample_o;
   logic [9:0] result_o;
   logic       done_o;
   logic       start_o;

   int checks = 0;
   int errors = 0;
   int ncyc = 0;
   int t_mux = 0, t_sh = 0, t_done = 0;
   int n_mux = 0, n_sh = 0, n_done = 0;
   int m0 = 0, s0 = 0, d0 = 0;
   logic done_prev = 1'b0;

   always #4 clk = ~clk;

   adc_seq_ctrl dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable_i   (enable_i),
      .start_wr_i (start_wr_i),
      .free_run_i (free_run_i),
      .diff_i     (diff_i),
      .div_sel_i  (div_sel_i),
      .cmp_i      (cmp_i),
      .done_clr_i (done_clr_i),
      .mux_upd_o  (mux_upd_o),
      .sample_o   (sample_o),
      .result_o   (result_o),
      .done_o     (done_o),
      .start_o    (start_o)
   );

   function automatic logic hbit(input int n);
      int x;
      x = (n * 7) ^ (n >>> 3) ^ (n >>> 5);
      return x[0];
   endfunction

   function automatic int ratio(input int code);
      return (code == 0) ? 2 : (1 << code);
   endfunction

   // first rise at or after observation cycle v, with odd index if odd_only
   function automatic int next_rise(input int e, input int dv, input int v, input bit odd_only);
      for (int j = 1; j < 100000; j++) begin
         if ((e + j * dv - 1) >= v && (!odd_only || j[0])) return e + j * dv - 1;
      end
      return -1;
   endfunction

   always @(posedge clk) ncyc = ncyc + 1;

   always @(negedge clk) begin
      cmp_i <= hbit(ncyc);
      if (mux_upd_o) begin t_mux = ncyc; n_mux = n_mux + 1; end
      if (sample_o)  begin t_sh = ncyc;  n_sh = n_sh + 1;   end
      if (done_o && !done_prev) begin t_done = ncyc; n_done = n_done + 1; end
      done_prev = done_o;
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic snap();
      m0 = n_mux; s0 = n_sh; d0 = n_done;
   endtask

   task automatic pulse_clr();
      @(negedge clk) done_clr_i = 1'b1;
      @(negedge clk) done_clr_i = 1'b0;
   endtask

   task automatic go_idle();
      @(negedge clk);
      enable_i = 1'b0; free_run_i = 1'b0; diff_i = 1'b0; start_wr_i = 1'b0;
      repeat (3) @(negedge clk);
      pulse_clr();
   endtask

   // follow one conversion; t0_in < 0 means wait for its start edge
   task automatic track(input int dv, input int len, input int shc, input int t0_in,
                        input int exp_t0, input bit single, input string rlen);
      int t0;
      logic [9:0] ev;
      if (t0_in < 0) begin
         wait (n_mux > m0);
         t0 = t_mux;
         chk("R2", "start edge", t0, exp_t0);
         chk("R2", "start bit during conversion", int'(start_o), 1);
      end else begin
         t0 = t0_in;
      end
      wait (n_sh > s0);
      chk("R6", "sample strobe", t_sh, t0 + shc * dv + dv / 2);
      wait (n_done > d0);
      chk(rlen, "completion time", t_done, t0 + len * dv + 1);
      for (int k = 0; k < 10; k++) ev[9 - k] = hbit(t0 + (len - 10 + k) * dv);
      chk("R7", "result", int'(result_o), int'(ev));
      if (single) chk("R9", "start bit after single completion", int'(start_o), 0);
   endtask

   task automatic test_code(input int code);
      int dv, e, s;
      dv = ratio(code);
      go_idle();
      div_sel_i = 3'(code);
      snap();
      @(negedge clk);
      e = ncyc; enable_i = 1'b1; start_wr_i = 1'b1;
      @(negedge clk) start_wr_i = 1'b0;
      // R1 R4: extended conversion, first rise at e+div-1
      track(dv, 25, 13, -1, e + dv - 1, 1'b1, "R4");
      repeat (3) @(negedge clk);
      chk("R8", "flag persists", int'(done_o), 1);
      pulse_clr();
      chk("R8", "flag cleared", int'(done_o), 0);
      repeat (code + 1) @(negedge clk);
      snap();
      start_wr_i = 1'b1; s = ncyc;
      @(negedge clk) start_wr_i = 1'b0;
      // R5: normal conversion from the next rise
      track(dv, 13, 1, -1, next_rise(e, dv, s + 1, 1'b0), 1'b1, "R5");
   endtask

   task automatic test_diff(input int code, input bit dmode);
      int dv, e, s;
      dv = ratio(code);
      go_idle();
      div_sel_i = 3'(code);
      diff_i = dmode;
      @(negedge clk);
      e = ncyc; enable_i = 1'b1;
      while (ncyc < e + dv) @(negedge clk);
      snap();
      start_wr_i = 1'b1; s = ncyc;
      @(negedge clk) start_wr_i = 1'b0;
      // R3: differential waits for an odd rise, single-ended does not
      track(dv, 25, 13, -1, next_rise(e, dv, s + 1, dmode), 1'b1, "R4");
      chk("R3", "start rise index", (t_mux - e + 1) / dv, dmode ? 3 : 2);
   endtask

   task automatic test_free_run();
      int dv, e, t1;
      dv = 4;
      go_idle();
      div_sel_i = 3'd2;
      free_run_i = 1'b1;
      snap();
      @(negedge clk);
      e = ncyc; enable_i = 1'b1; start_wr_i = 1'b1;
      @(negedge clk) start_wr_i = 1'b0;
      track(dv, 25, 13, -1, e + dv - 1, 1'b0, "R4");
      chk("R10", "restart count", n_mux - m0, 2);
      chk("R10", "restart on completion rise", t_mux, t_done - 1);
      chk("R10", "start bit kept", int'(start_o), 1);
      t1 = t_mux;
      s0 = n_sh; d0 = n_done;
      free_run_i = 1'b0;
      pulse_clr();
      track(dv, 13, 1, t1, 0, 1'b1, "R10");
   endtask

   task automatic test_abort();
      int e, mm, dd;
      go_idle();
      div_sel_i = 3'd1;
      @(negedge clk) start_wr_i = 1'b1;
      @(negedge clk) start_wr_i = 1'b0;
      mm = n_mux;
      @(negedge clk) enable_i = 1'b1;
      repeat (10) @(negedge clk);
      chk("R2", "start write while disabled ignored", int'(start_o), 0);
      chk("R2", "no conversion from ignored write", n_mux - mm, 0);
      start_wr_i = 1'b1;
      @(negedge clk) start_wr_i = 1'b0;
      wait (n_mux > mm);
      repeat (8) @(negedge clk);
      dd = n_done;
      enable_i = 1'b0;
      repeat (2) @(negedge clk);
      chk("R11", "start bit cleared by disable", int'(start_o), 0);
      repeat (60) @(negedge clk);
      chk("R11", "aborted conversion sets no flag", int'(done_o), 0);
      chk("R11", "no completion", n_done - dd, 0);
      snap();
      @(negedge clk);
      e = ncyc; enable_i = 1'b1; start_wr_i = 1'b1;
      @(negedge clk) start_wr_i = 1'b0;
      track(2, 25, 13, -1, e + 1, 1'b1, "R11");
   endtask

   initial begin
      fork
         begin
            repeat (4) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            chk("R8", "reset flag", int'(done_o), 0);
            chk("R2", "reset start bit", int'(start_o), 0);
            chk("R7", "reset result", int'(result_o), 0);
            for (int c = 0; c < 8; c++) test_code(c);   // R1 for every code
            test_diff(1, 1'b0);
            test_diff(1, 1'b1);
            test_diff(4, 1'b0);
            test_diff(4, 1'b1);
            test_free_run();
            test_abort();
         end
         begin
            repeat (150000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule